// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block decodes the bus write traffic of a parallel NOR flash that uses the classic multi-cycle unlock command protocol. Each write strobe carries a byte address and a data word. The low byte of the data is the command code. The sequencer checks each address/data pair against the expected step of a sequence. It keeps track of which command is active. When a program, a sector erase or a chip erase is fully unlocked, it raises a one-cycle request pulse toward the array controller.

The sequencer also tells the read data path what a read should return. The options are array contents, identification words, the status word or the query table. An unlock-bypass mode lets software issue program and erase commands without repeating the two unlock cycles. A reset code returns the block to array reads from almost any step.

The storage array, the read multiplexing and the erase timing are handled elsewhere. The erase controller reports back through a busy input and a done input.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `read_mode_o` is 0 (array), `bypass_o` is 0 and all three request pulses are low. The `read_mode_o` encoding is 0 = array, 1 = identification, 2 = status, 3 = query table.
- R2: A command address is compared as a word offset. The word offset is the byte address modulo the sector size (2^SECT_W bytes), shifted right by 0, 1 or 2 for a 1-, 2- or 4-byte bus. Bits above the sector window and the byte-lane bits do not affect the match.
- R3: The first unlock step needs data 0xAA at word offset UNLOCK0. The second needs 0x55 at UNLOCK1. Any other pair returns the sequencer to idle.
- R4: Outside bypass, the third step must be at UNLOCK0. Its data selects the command: 0x20 enters bypass, 0x80 starts the erase prefix, 0x90 enters identification mode and 0xA0 arms a program. Any other value returns to idle.
- R5: While a program is armed, `read_mode_o` is status. The next write raises `prog_req_o` with the byte address on `prog_addr_o` and the full data word on `prog_data_o`. The sequencer then returns to array mode.
- R6: A write of 0xF0 returns to idle and clears bypass, except in two cases. While a program is armed, 0xF0 is taken as program data. While an erase is running, it is ignored.
- R7: In idle, and at the first step after the erase prefix, a write of 0x98 at word offset 0x55 enters query mode. Any write in query mode returns to idle.
- R8: In identification mode, a write of 0x98 at word offset 0x55 moves to query mode. Any other write returns to idle.
- R9: After the erase prefix, a second 0xAA/0x55 unlock pair must follow. Then 0x10 at UNLOCK0 raises `chip_erase_req_o`. Alternatively, 0x30 at any address raises `sect_erase_req_o` with `erase_sect_o` set to the address bits above the sector window.
- R10: While an erase runs, `read_mode_o` is status and writes are ignored. A high `erase_done_i` ends the erase and returns to idle, or to command-ready when bypass is active.
- R11: With bypass active, the command step is accepted at any address. After a program or a completed erase, the sequencer returns directly to command-ready without unlock cycles.
- R12: In identification mode with bypass active, a write of 0x00 clears bypass and returns to idle. Any reset path also clears bypass.
- R13: A write is ignored while `erase_busy_i` is high.
- R14: Each request is high for exactly one cycle, and at most one request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 8*BUS_BYTES | Write data; the low byte is the command code |
| erase_busy_i | input | 1 | Erase controller busy; writes are ignored while high |
| erase_done_i | input | 1 | Erase finished |
| prog_req_o | output | 1 | Program request pulse |
| prog_addr_o | output | ADDR_W | Byte address to program |
| prog_data_o | output | 8*BUS_BYTES | Data to program |
| sect_erase_req_o | output | 1 | Sector erase request pulse |
| erase_sect_o | output | ADDR_W-SECT_W | Index of the sector to erase |
| chip_erase_req_o | output | 1 | Chip erase request pulse |
| read_mode_o | output | 2 | Read source: 0 array, 1 identification, 2 status, 3 query table |
| bypass_o | output | 1 | Unlock bypass active |

## Verification
Every output is registered. A write sampled on a rising edge therefore shows its effect on the mode, bypass and request outputs right after that same edge, with one cycle of latency. The bench drives each write for one cycle from a falling edge. It samples at the next falling edge, where a request pulse must be high. It samples again one falling edge later, where the pulse must already be low. For sequences that must be rejected or ignored, the bench completes what would otherwise be a valid command. It then confirms at that same sampling point that no request appears and that the mode output has not moved.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLK1, ST_READY, ST_PROG, ST_AUTOSEL,
    ST_ERS_U0, ST_ERS_U1, ST_ERS_CMD, ST_ERASING, ST_CFI
  } seq_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_ID     = 2'd1,
    RM_STATUS = 2'd2,
    RM_CFI    = 2'd3
  } read_mode_e;

  typedef struct packed {
    logic prog;
    logic sect;
    logic chip;
  } req_t;

  localparam logic [7:0] CMD_UNLK_A   = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B   = 8'h55;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_ERS_PFX  = 8'h80;
  localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
  localparam logic [7:0] CMD_PROG     = 8'hA0;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECT     = 8'h30;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_BYP_EXIT = 8'h00;
  localparam int unsigned QUERY_OFF   = 'h55;

endpackage

// File: rtl/nor_addr_norm.sv
module nor_addr_norm #(
  parameter int ADDR_W    = 20,
  parameter int SECT_W    = 16,
  parameter int BUS_BYTES = 2,
  localparam int SHIFT    = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0,
  localparam int OFF_W    = SECT_W - SHIFT,
  localparam int SIDX_W   = ADDR_W - SECT_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OFF_W-1:0]  off_o,
  output logic [SIDX_W-1:0] sect_o
);

  assign sect_o = addr_i[ADDR_W-1:SECT_W];

  generate
    if (SHIFT == 0) begin : g_byte
      assign off_o = addr_i[SECT_W-1:0];
    end else begin : g_wide
      logic unused_lanes;
      assign off_o        = addr_i[SECT_W-1:SHIFT];
      assign unused_lanes = ^addr_i[SHIFT-1:0];
    end
  endgenerate

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int OFF_W   = 15,
  parameter int UNLOCK0 = 'h555,
  parameter int UNLOCK1 = 'h2AA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       data_i,
  input  logic             busy_i,
  input  logic             done_i,
  output seq_state_e       state_d,
  output req_t             req_d,
  output logic             bypass_q
);

  localparam logic [OFF_W-1:0] U0_OFF = OFF_W'(UNLOCK0);
  localparam logic [OFF_W-1:0] U1_OFF = OFF_W'(UNLOCK1);
  localparam logic [OFF_W-1:0] QY_OFF = OFF_W'(QUERY_OFF);

  seq_state_e state_q;
  logic       bypass_d;
  logic       drop;
  logic       at_u0, at_u1, hit_query;

  assign at_u0     = (off_i == U0_OFF);
  assign at_u1     = (off_i == U1_OFF);
  assign hit_query = (off_i == QY_OFF) && (data_i == CMD_QUERY);

  always_comb begin
    state_d  = state_q;
    bypass_d = bypass_q;
    req_d    = '0;
    drop     = 1'b0;
    if (state_q == ST_ERASING) begin
      if (done_i) state_d = bypass_q ? ST_READY : ST_IDLE;
    end else if (wr_en_i && !busy_i) begin
      if (data_i == CMD_RESET && state_q != ST_PROG) begin
        drop = 1'b1;
      end else begin
        case (state_q)
          ST_IDLE, ST_ERS_U0: begin
            if (hit_query)                          state_d = ST_CFI;
            else if (at_u0 && data_i == CMD_UNLK_A) state_d = (state_q == ST_IDLE) ? ST_UNLK1 : ST_ERS_U1;
            else                                    drop = 1'b1;
          end
          ST_UNLK1: begin
            if (at_u1 && data_i == CMD_UNLK_B) state_d = ST_READY;
            else                               drop = 1'b1;
          end
          ST_READY: begin
            if (!bypass_q && !at_u0) drop = 1'b1;
            else begin
              case (data_i)
                CMD_BYPASS:  bypass_d = 1'b1;
                CMD_ERS_PFX: state_d  = ST_ERS_U0;
                CMD_AUTOSEL: state_d  = ST_AUTOSEL;
                CMD_PROG:    state_d  = ST_PROG;
                default:     drop     = 1'b1;
              endcase
            end
          end
          ST_PROG: begin
            req_d.prog = 1'b1;
            state_d    = bypass_q ? ST_READY : ST_IDLE;
          end
          ST_AUTOSEL: begin
            if (bypass_q && data_i == CMD_BYP_EXIT) drop = 1'b1;
            else if (hit_query)                     state_d = ST_CFI;
            else                                    drop = 1'b1;
          end
          ST_ERS_U1: begin
            if (at_u1 && data_i == CMD_UNLK_B) state_d = ST_ERS_CMD;
            else                               drop = 1'b1;
          end
          ST_ERS_CMD: begin
            if (data_i == CMD_CHIP && at_u0) begin
              req_d.chip = 1'b1;
              state_d    = ST_ERASING;
            end else if (data_i == CMD_SECT) begin
              req_d.sect = 1'b1;
              state_d    = ST_ERASING;
            end else begin
              drop = 1'b1;
            end
          end
          default: drop = 1'b1;
        endcase
      end
      if (drop) begin
        state_d  = ST_IDLE;
        bypass_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bypass_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bypass_q <= bypass_d;
    end
  end

  p_busy_freeze_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && state_q != ST_ERASING) |=> ($stable(state_q) && $stable(bypass_q)));

  p_erase_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASING && !done_i) |=> (state_q == ST_ERASING));

  p_cfi_leave_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CFI && wr_en_i && !busy_i) |=> (state_q == ST_IDLE && !bypass_q));

  p_bypass_entry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bypass_q) |-> $past(wr_en_i && data_i == CMD_BYPASS));

endmodule

// File: rtl/nor_out_reg.sv
module nor_out_reg
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SIDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_d,
  input  req_t              req_d,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SIDX_W-1:0] sect_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              sect_req_o,
  output logic [SIDX_W-1:0] sect_o,
  output logic              chip_req_o,
  output read_mode_e        mode_o
);

  read_mode_e mode_d;

  always_comb begin
    case (state_d)
      ST_AUTOSEL:          mode_d = RM_ID;
      ST_CFI:              mode_d = RM_CFI;
      ST_PROG, ST_ERASING: mode_d = RM_STATUS;
      default:             mode_d = RM_ARRAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_req_o  <= 1'b0;
      sect_req_o  <= 1'b0;
      chip_req_o  <= 1'b0;
      prog_addr_o <= '0;
      prog_data_o <= '0;
      sect_o      <= '0;
      mode_o      <= RM_ARRAY;
    end else begin
      prog_req_o <= req_d.prog;
      sect_req_o <= req_d.sect;
      chip_req_o <= req_d.chip;
      mode_o     <= mode_d;
      if (req_d.prog) begin
        prog_addr_o <= addr_i;
        prog_data_o <= data_i;
      end
      if (req_d.sect) sect_o <= sect_i;
    end
  end

  p_req_onehot_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, sect_req_o, chip_req_o}));

  p_req_pulse_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o || sect_req_o || chip_req_o) |=> !(prog_req_o || sect_req_o || chip_req_o));

  p_erase_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sect_req_o || chip_req_o) |-> (mode_o == RM_STATUS));

  p_prog_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (mode_o == RM_ARRAY));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SECT_W    = 16,
  parameter int BUS_BYTES = 2,
  parameter int UNLOCK0   = 'h555,
  parameter int UNLOCK1   = 'h2AA
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [8*BUS_BYTES-1:0]    wr_data_i,
  input  logic                      erase_busy_i,
  input  logic                      erase_done_i,
  output logic                      prog_req_o,
  output logic [ADDR_W-1:0]         prog_addr_o,
  output logic [8*BUS_BYTES-1:0]    prog_data_o,
  output logic                      sect_erase_req_o,
  output logic [ADDR_W-SECT_W-1:0]  erase_sect_o,
  output logic                      chip_erase_req_o,
  output logic [1:0]                read_mode_o,
  output logic                      bypass_o
);

  localparam int DATA_W = 8 * BUS_BYTES;
  localparam int SHIFT  = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;
  localparam int OFF_W  = SECT_W - SHIFT;
  localparam int SIDX_W = ADDR_W - SECT_W;

  logic [OFF_W-1:0]  word_off;
  logic [SIDX_W-1:0] sect_idx;
  seq_state_e        state_d;
  req_t              req_d;
  read_mode_e        mode;

  nor_addr_norm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BUS_BYTES(BUS_BYTES)) u_norm (
    .addr_i (wr_addr_i),
    .off_o  (word_off),
    .sect_o (sect_idx)
  );

  nor_cmd_fsm #(.OFF_W(OFF_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .off_i    (word_off),
    .data_i   (wr_data_i[7:0]),
    .busy_i   (erase_busy_i),
    .done_i   (erase_done_i),
    .state_d  (state_d),
    .req_d    (req_d),
    .bypass_q (bypass_o)
  );

  nor_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIDX_W(SIDX_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_d     (state_d),
    .req_d       (req_d),
    .addr_i      (wr_addr_i),
    .data_i      (wr_data_i),
    .sect_i      (sect_idx),
    .prog_req_o  (prog_req_o),
    .prog_addr_o (prog_addr_o),
    .prog_data_o (prog_data_o),
    .sect_req_o  (sect_erase_req_o),
    .sect_o      (erase_sect_o),
    .chip_req_o  (chip_erase_req_o),
    .mode_o      (mode)
  );

  assign read_mode_o = mode;

endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

  localparam int MD_ARR = 0, MD_ID = 1, MD_ST = 2, MD_CFI = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        done = 1'b0;
  logic        prog_req, sect_req, chip_req, bypass;
  logic [19:0] prog_addr;
  logic [15:0] prog_data;
  logic [3:0]  esect;
  logic [1:0]  mode;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  nor_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .erase_busy_i(busy), .erase_done_i(done),
    .prog_req_o(prog_req), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .sect_erase_req_o(sect_req), .erase_sect_o(esect), .chip_erase_req_o(chip_req),
    .read_mode_o(mode), .bypass_o(bypass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr_b(input logic [19:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_w(input logic [19:0] w, input logic [15:0] d);
    wr_b(w << 1, d);
  endtask

  task automatic unlock();
    wr_w(20'h555, 16'h00AA);
    wr_w(20'h2AA, 16'h0055);
  endtask

  task automatic no_req(input string tag);
    chk(tag, {prog_req, sect_req, chip_req}, 3'b000);
  endtask

  task automatic t_reset();
    chk("R1 mode after reset", mode, MD_ARR);
    chk("R1 bypass after reset", bypass, 0);
    no_req("R1 reqs after reset");
  endtask

  task automatic t_program();
    unlock();
    chk("R3 mode during unlock", mode, MD_ARR);
    wr_w(20'h555, 16'h00A0);
    chk("R5 armed status mode", mode, MD_ST);
    wr_b(20'h01234, 16'hBE3C);
    chk("R5 prog pulse", prog_req, 1);
    chk("R5 prog addr", prog_addr, 20'h01234);
    chk("R5 prog data", prog_data, 16'hBE3C);
    chk("R5 back to array", mode, MD_ARR);
    @(negedge clk);
    chk("R14 prog one cycle", prog_req, 0);
  endtask

  task automatic t_f0_as_data();
    unlock();
    wr_w(20'h555, 16'h00A0);
    wr_b(20'h00200, 16'h00F0);
    chk("R6 F0 taken as program data", prog_req, 1);
    chk("R6 F0 data value", prog_data, 16'h00F0);
    @(negedge clk);
  endtask

  task automatic t_bad_unlock();
    wr_w(20'h555, 16'h00AA);
    wr_w(20'h2AA, 16'h0054);
    wr_w(20'h555, 16'h00A0);
    chk("R3 bad second unlock not armed", mode, MD_ARR);
    wr_b(20'h00300, 16'h1111);
    chk("R3 no program after bad unlock", prog_req, 0);
    wr_w(20'h554, 16'h00AA);
    wr_w(20'h2AA, 16'h0055);
    wr_w(20'h555, 16'h0090);
    chk("R3 bad first unlock address", mode, MD_ARR);
  endtask

  task automatic t_bad_cmd();
    unlock();
    wr_w(20'h100, 16'h00A0);
    chk("R4 command at wrong address", mode, MD_ARR);
    wr_b(20'h00300, 16'h2222);
    chk("R4 no program", prog_req, 0);
    unlock();
    wr_w(20'h555, 16'h0077);
    chk("R4 unknown command resets", mode, MD_ARR);
    wr_w(20'h555, 16'h00A0);
    chk("R4 unknown command left idle", mode, MD_ARR);
  endtask

  task automatic t_autoselect();
    unlock();
    wr_w(20'h555, 16'h0090);
    chk("R8 ID mode", mode, MD_ID);
    wr_w(20'h055, 16'h0098);
    chk("R8 ID to query", mode, MD_CFI);
    wr_w(20'h123, 16'h0000);
    chk("R7 query left on write", mode, MD_ARR);
    unlock();
    wr_w(20'h555, 16'h0090);
    wr_w(20'h100, 16'h0012);
    chk("R8 other write leaves ID", mode, MD_ARR);
  endtask

  task automatic t_cfi_idle();
    wr_w(20'h055, 16'h0098);
    chk("R7 query from idle", mode, MD_CFI);
    wr_w(20'h000, 16'h00F0);
    chk("R7 reset out of query", mode, MD_ARR);
    wr_w(20'h056, 16'h0098);
    chk("R7 wrong query address", mode, MD_ARR);
  endtask

  task automatic t_f0_mid();
    wr_w(20'h555, 16'h00AA);
    wr_w(20'h2AA, 16'h00F0);
    wr_w(20'h2AA, 16'h0055);
    wr_w(20'h555, 16'h0090);
    chk("R6 F0 aborts unlock", mode, MD_ARR);
  endtask

  task automatic t_chip_erase();
    unlock();
    wr_w(20'h555, 16'h0080);
    unlock();
    wr_w(20'h555, 16'h0010);
    chk("R9 chip erase pulse", chip_req, 1);
    chk("R10 status during erase", mode, MD_ST);
    @(negedge clk);
    chk("R14 chip pulse one cycle", chip_req, 0);
    wr_w(20'h000, 16'h00F0);
    chk("R10 F0 ignored in erase", mode, MD_ST);
    unlock();
    wr_w(20'h555, 16'h0090);
    chk("R10 writes ignored in erase", mode, MD_ST);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk("R10 done returns to array", mode, MD_ARR);
    chk("R10 bypass stays off", bypass, 0);
  endtask

  task automatic t_chip_bad_addr();
    unlock();
    wr_w(20'h555, 16'h0080);
    unlock();
    wr_w(20'h100, 16'h0010);
    no_req("R9 chip erase needs unlock address");
    chk("R9 reset after bad chip erase", mode, MD_ARR);
  endtask

  task automatic t_sect_erase();
    unlock();
    wr_w(20'h555, 16'h0080);
    unlock();
    wr_b(20'h23456, 16'h0030);
    chk("R9 sector erase pulse", sect_req, 1);
    chk("R9 sector index", esect, 4'h2);
    chk("R14 only sector pulse", {prog_req, chip_req}, 2'b00);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk("R10 sector done", mode, MD_ARR);
  endtask

  task automatic t_bypass();
    unlock();
    wr_w(20'h555, 16'h0020);
    chk("R11 bypass on", bypass, 1);
    wr_w(20'h040, 16'h00A0);
    chk("R11 armed at any address", mode, MD_ST);
    wr_b(20'h00500, 16'h5A5A);
    chk("R11 bypass program", prog_req, 1);
    wr_w(20'h077, 16'h00A0);
    wr_b(20'h00502, 16'hA5A5);
    chk("R11 second program without unlock", prog_req, 1);
    chk("R11 second program addr", prog_addr, 20'h00502);
    wr_w(20'h080, 16'h0080);
    unlock();
    wr_b(20'h31000, 16'h0030);
    chk("R11 bypass sector erase", sect_req, 1);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk("R11 bypass kept after erase", bypass, 1);
    wr_w(20'h011, 16'h0090);
    chk("R12 ID under bypass", mode, MD_ID);
    wr_w(20'h011, 16'h0000);
    chk("R12 exit bypass", bypass, 0);
    wr_w(20'h040, 16'h00A0);
    chk("R12 no shortcut after exit", mode, MD_ARR);
    unlock();
    wr_w(20'h555, 16'h0020);
    wr_w(20'h000, 16'h00F0);
    chk("R6 F0 clears bypass", bypass, 0);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    unlock();
    wr_w(20'h555, 16'h00A0);
    chk("R13 writes ignored while busy", mode, MD_ARR);
    busy = 1'b0;
    wr_b(20'h00600, 16'h3333);
    chk("R13 no program", prog_req, 0);
  endtask

  task automatic t_norm();
    wr_b(20'h10AAB, 16'h00AA);
    wr_b(20'hF0554, 16'h0055);
    wr_b(20'h00AAA, 16'h0090);
    chk("R2 offset within sector and lane bits ignored", mode, MD_ID);
    wr_w(20'h000, 16'h00F0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_f0_as_data();
    t_bad_unlock();
    t_bad_cmd();
    t_autoselect();
    t_cfi_idle();
    t_f0_mid();
    t_chip_erase();
    t_chip_bad_addr();
    t_sect_erase();
    t_bypass();
    t_busy();
    t_norm();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule